// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode controller of a single-wire bus transceiver. The analog parts (supply comparators, the regulator, the bus driver and the wake-up detector) stay outside and reach it as digital flags. The block keeps the transceiver in one of five modes: Unpowered, Fail-safe, Normal, Silent and Sleep. It drives the regulator enable, the active-low reset output, the bus termination enable and the transmitter enable from that mode. While the transceiver is in Fail-safe, the block also drives a two-bit code on the receive and transmit pins that tells the host controller why Fail-safe was entered.

The host uses the enable pin to move the transceiver between modes. A high enable pin brings the transceiver from Fail-safe into Normal. A falling edge on the enable pin in Normal opens a mode-select window of `WIN_CYC` clock cycles. The level of the transmit pin at the end of that window chooses the low-power mode: high selects Silent and low selects Sleep. Both pins pass through two-flop synchronisers before any edge detection. Every exit from a low-power mode and every fault exit goes through Fail-safe, so the host always reads the wake source before it returns to Normal.

Internal states: UNPWR, FSAFE, NORM, MSEL (the select window, reported as Normal), SILENT and SLEEP. The named transitions are:

- power-up (UNPWR to FSAFE)
- supply loss (any powered state to UNPWR)
- enable (FSAFE to NORM)
- select start (NORM to MSEL)
- select quiet (MSEL to SILENT)
- select deep (MSEL to SLEEP)
- undervoltage fault (NORM, MSEL or SILENT to FSAFE)
- bus wake (SILENT or SLEEP to FSAFE)

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: During and after reset, with no supply flag set, mode reads 0 (Unpowered), and vreg_en, nres, term_en, tx_en and txd_oe are all 0.
- R2: In Unpowered, vs_above high moves mode to 1 (Fail-safe) at the next clock. Fail-safe drives vreg_en=1, term_en=1, tx_en=0 and txd_oe=1, and shows the power-up code rxd_drv=1, txd_drv=1.
- R3: In any powered mode (1 to 4), vs_below high moves mode to 0 at the next clock, with priority over every other input.
- R4: In Fail-safe, a synchronised high enable pin with vcc_uv low moves mode to 2 (Normal). Normal drives vreg_en=1, nres=1, term_en=1, tx_en=1 and txd_oe=0.
- R5: A falling edge of the enable pin in Normal keeps mode at 2 for WIN_CYC further cycles. The synchronised transmit pin is then sampled, and a high level moves mode to 3 (Silent). A level that changes inside the window has no effect; only the level at the window's end counts.
- R6: A low transmit level at the end of the window moves mode to 4 (Sleep). Sleep drives vreg_en=0, nres=0, term_en=0 and tx_en=0.
- R7: Silent drives vreg_en=1, nres=1, tx_en=0 and term_en=0. A high enable pin in Silent leaves mode at 3.
- R8: vcc_uv high in Normal or Silent moves mode to 1 at the next clock. At that point nres=0 and the code is rxd_drv=1, txd_drv=0. vcc_uv in Fail-safe keeps mode at 1, and vcc_uv in Sleep keeps mode at 4.
- R9: A wake_req strobe in Silent or Sleep moves mode to 1 at the next clock. The block then drives vreg_en=1 and term_en=1, and shows the wake code rxd_drv=0, txd_drv=0.
- R10: A wake_req strobe in Unpowered, Fail-safe or Normal is ignored: mode does not change.
- R11: Normal is entered only from Fail-safe. The Fail-safe code stays unchanged for as long as mode stays 1, and the block releases txd_oe when it enters Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin from the host, asynchronous |
| txd_pin | input | 1 | Transmit pin level, asynchronous |
| vs_above | input | 1 | Supply above the power-up threshold |
| vs_below | input | 1 | Supply below the undervoltage threshold |
| vcc_uv | input | 1 | Regulator output in undervoltage |
| wake_req | input | 1 | One-cycle bus wake strobe from the detector |
| mode | output | 3 | 0 Unpowered, 1 Fail-safe, 2 Normal, 3 Silent, 4 Sleep |
| vreg_en | output | 1 | Regulator enable |
| nres | output | 1 | Active-low reset to the host |
| term_en | output | 1 | Bus termination enable |
| tx_en | output | 1 | Transmitter enable |
| rxd_drv | output | 1 | Value driven on the receive pin |
| txd_drv | output | 1 | Value driven on the transmit pin while txd_oe is high |
| txd_oe | output | 1 | Transmit pin acts as an output (Fail-safe only) |

## Verification
The assertions assume that the supply, regulator and wake flags are already synchronous to clk, and that vs_above and vs_below are never high together. They also assume that wake_req lasts a single cycle. The stimulus meets these conditions as follows:

- It changes every input only at the falling clock edge.
- It drops vs_above whenever it raises vs_below.
- It raises wake_req for exactly one cycle.
- It holds the enable and transmit pins long enough for the synchronisers and the select window to settle before it checks any result.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

    typedef enum logic [2:0] {
        ST_UNPWR  = 3'd0,
        ST_FSAFE  = 3'd1,
        ST_NORM   = 3'd2,
        ST_MSEL   = 3'd3,
        ST_SILENT = 3'd4,
        ST_SLEEP  = 3'd5
    } state_t;

    typedef enum logic [1:0] {
        SRC_PWR  = 2'd0,
        SRC_WAKE = 2'd1,
        SRC_UV   = 2'd2
    } src_t;

    localparam logic [2:0] MODE_UNPWR  = 3'd0;
    localparam logic [2:0] MODE_FSAFE  = 3'd1;
    localparam logic [2:0] MODE_NORM   = 3'd2;
    localparam logic [2:0] MODE_SILENT = 3'd3;
    localparam logic [2:0] MODE_SLEEP  = 3'd4;

endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xmc_win_timer.sv
module xmc_win_timer #(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || done)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < WIN_CYC);

    // R5
    win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xmc_pkg::*;
#(
    parameter int WIN_CYC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       txd_pin,
    input  logic       vs_above,
    input  logic       vs_below,
    input  logic       vcc_uv,
    input  logic       wake_req,
    output logic [2:0] mode,
    output logic       vreg_en,
    output logic       nres,
    output logic       term_en,
    output logic       tx_en,
    output logic       rxd_drv,
    output logic       txd_drv,
    output logic       txd_oe
);
    state_t st, st_nxt;
    src_t   src, src_nxt;
    logic   en_s, txd_s, en_d, en_fall, win_done, uv_q;
    logic [1:0] pins_s;

    xmc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({en_pin, txd_pin}), .q(pins_s)
    );
    assign en_s  = pins_s[1];
    assign txd_s = pins_s[0];

    xmc_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .run(st == ST_MSEL), .done(win_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d <= 1'b0;
            uv_q <= 1'b0;
        end else begin
            en_d <= en_s;
            uv_q <= vcc_uv;
        end
    end
    assign en_fall = en_d && !en_s;

    // next-state selection
    always_comb begin
        st_nxt  = st;
        src_nxt = src;
        if (st != ST_UNPWR && vs_below) begin
            st_nxt = ST_UNPWR;
        end else begin
            unique case (st)
                ST_UNPWR: if (vs_above) begin
                    st_nxt = ST_FSAFE; src_nxt = SRC_PWR;
                end
                ST_FSAFE: if (en_s && !vcc_uv) st_nxt = ST_NORM;
                ST_NORM: begin
                    if (vcc_uv) begin
                        st_nxt = ST_FSAFE; src_nxt = SRC_UV;
                    end else if (en_fall) begin
                        st_nxt = ST_MSEL;
                    end
                end
                ST_MSEL: begin
                    if (vcc_uv) begin
                        st_nxt = ST_FSAFE; src_nxt = SRC_UV;
                    end else if (win_done) begin
                        st_nxt = txd_s ? ST_SILENT : ST_SLEEP;
                    end
                end
                ST_SILENT: begin
                    if (vcc_uv) begin
                        st_nxt = ST_FSAFE; src_nxt = SRC_UV;
                    end else if (wake_req) begin
                        st_nxt = ST_FSAFE; src_nxt = SRC_WAKE;
                    end
                end
                ST_SLEEP: if (wake_req) begin
                    st_nxt = ST_FSAFE; src_nxt = SRC_WAKE;
                end
                default: st_nxt = ST_UNPWR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_UNPWR;
            src <= SRC_PWR;
        end else begin
            st  <= st_nxt;
            src <= src_nxt;
        end
    end

    // outputs
    logic reg_on;
    always_comb begin
        mode    = MODE_UNPWR;
        reg_on  = 1'b0;
        term_en = 1'b0;
        tx_en   = 1'b0;
        rxd_drv = 1'b1;
        txd_drv = 1'b1;
        txd_oe  = 1'b0;
        unique case (st)
            ST_UNPWR: mode = MODE_UNPWR;
            ST_FSAFE: begin
                mode    = MODE_FSAFE;
                reg_on  = 1'b1;
                term_en = 1'b1;
                txd_oe  = 1'b1;
                unique case (src)
                    SRC_WAKE: begin rxd_drv = 1'b0; txd_drv = 1'b0; end
                    SRC_UV:   begin rxd_drv = 1'b1; txd_drv = 1'b0; end
                    default:  begin rxd_drv = 1'b1; txd_drv = 1'b1; end
                endcase
            end
            ST_NORM, ST_MSEL: begin
                mode    = MODE_NORM;
                reg_on  = 1'b1;
                term_en = 1'b1;
                tx_en   = 1'b1;
            end
            ST_SILENT: begin
                mode   = MODE_SILENT;
                reg_on = 1'b1;
            end
            ST_SLEEP: mode = MODE_SLEEP;
            default:  mode = MODE_UNPWR;
        endcase
    end
    assign vreg_en = reg_on;
    assign nres    = reg_on && !uv_q;

    // R3
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_UNPWR && vs_below) |=> st == ST_UNPWR);

    // R9
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((st == ST_SILENT && !vcc_uv) || st == ST_SLEEP) && wake_req && !vs_below)
        |=> (st == ST_FSAFE && !rxd_drv && !txd_drv && vreg_en));

    // R8
    uv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORM && vcc_uv && !vs_below)
        |=> (st == ST_FSAFE && !nres && rxd_drv && !txd_drv));

    // R11
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORM) |-> ($past(st) == ST_NORM || $past(st) == ST_FSAFE));

    // R5
    silent_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SILENT) |-> ($past(st) == ST_MSEL || $past(st) == ST_SILENT));

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> ($past(st) == ST_MSEL || $past(st) == ST_SLEEP));

    // R10
    wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORM && wake_req && !vcc_uv && !vs_below && !en_fall)
        |=> st == ST_NORM);
endmodule

// File: tb/xcvr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_tb_top;
    localparam int WIN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0, txd_pin = 1'b1, vs_above = 1'b0, vs_below = 1'b0;
    logic vcc_uv = 1'b0, wake_req = 1'b0;
    logic [2:0] mode;
    logic vreg_en, nres, term_en, tx_en, rxd_drv, txd_drv, txd_oe;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xcvr_mode_ctrl #(.WIN_CYC(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .txd_pin(txd_pin),
        .vs_above(vs_above), .vs_below(vs_below), .vcc_uv(vcc_uv),
        .wake_req(wake_req), .mode(mode), .vreg_en(vreg_en), .nres(nres),
        .term_en(term_en), .tx_en(tx_en), .rxd_drv(rxd_drv),
        .txd_drv(txd_drv), .txd_oe(txd_oe)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // {vreg_en, nres, term_en, tx_en} per mode code
    function automatic int exp_outs(int m);
        case (m)
            1: return 4'b1110;
            2: return 4'b1111;
            3: return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk_outs(string req);
        chk(req, int'({vreg_en, nres, term_en, tx_en}), exp_outs(int'(mode)));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; en_pin = 0; txd_pin = 1; vs_above = 0; vs_below = 0;
        vcc_uv = 0; wake_req = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    // drive the controller into mode code m
    task automatic go_to(int m);
        do_reset();
        if (m == 0) return;
        vs_above = 1; tick(1);
        if (m == 1) return;
        en_pin = 1; tick(4);
        if (m == 2) return;
        txd_pin = (m == 3); en_pin = 0; tick(WIN + 5);
    endtask

    function automatic int exp_next(int s, int ev);
        case (ev)
            0: return 0;
            1: return (s == 2 || s == 3) ? 1 : s;
            default: return (s == 3 || s == 4) ? 1 : s;
        endcase
    endfunction

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 outs", int'({vreg_en, nres, term_en, tx_en, txd_oe}), 0);

        // R2 power-up
        vs_above = 1; tick(1);
        chk("R2 mode", mode, 1);
        chk("R2 code", int'({rxd_drv, txd_drv, txd_oe}), 3'b111);
        chk_outs("R2 outs");
        tick(6);
        chk("R11 code held", int'({rxd_drv, txd_drv}), 2'b11);

        // R4 enable into Normal
        en_pin = 1; tick(4);
        chk("R4 mode", mode, 2);
        chk_outs("R4 outs");
        chk("R11 oe released", txd_oe, 0);

        // R5 window timing, txd low early then high at the window end
        txd_pin = 0; en_pin = 0;
        tick(3); txd_pin = 1;
        tick(WIN - 1);
        chk("R5 still normal in window", mode, 2);
        tick(1);
        chk("R5 silent", mode, 3);
        chk_outs("R7 outs");
        en_pin = 1; tick(6);
        chk("R7 en high ignored", mode, 3);

        // R6 sleep select
        go_to(2);
        txd_pin = 0; en_pin = 0; tick(2 + WIN);
        chk("R6 still normal in window", mode, 2);
        tick(1);
        chk("R6 sleep", mode, 4);
        chk_outs("R6 outs");

        // R9 wake from sleep, code held until Normal (R11)
        wake_req = 1; tick(1); wake_req = 0;
        chk("R9 mode", mode, 1);
        chk("R9 code", int'({rxd_drv, txd_drv}), 2'b00);
        chk_outs("R9 outs");
        tick(5);
        chk("R11 wake code held", int'({rxd_drv, txd_drv}), 2'b00);
        en_pin = 1; tick(4);
        chk("R11 normal from fail-safe", mode, 2);

        // sweep: every start mode against every event (R3, R8, R9, R10)
        for (int s = 0; s < 5; s++) begin
            for (int ev = 0; ev < 3; ev++) begin
                int e;
                go_to(s);
                chk("R4 setup mode", mode, s);
                e = exp_next(s, ev);
                case (ev)
                    0: begin vs_below = 1; vs_above = 0; end
                    1: vcc_uv = 1;
                    default: wake_req = 1;
                endcase
                tick(1);
                wake_req = 0;
                case (ev)
                    0: chk("R3 supply loss", mode, e);
                    1: chk("R8 undervoltage", mode, e);
                    default: chk((s < 3) ? "R10 wake ignored" : "R9 wake", mode, e);
                endcase
                if (ev == 1 && (s == 2 || s == 3))
                    chk("R8 nres/code", int'({nres, rxd_drv, txd_drv}), 3'b010);
                if (ev == 2 && (s == 3 || s == 4))
                    chk("R9 code", int'({rxd_drv, txd_drv, term_en}), 3'b001);
                vcc_uv = 0; vs_below = 0;
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule